// File: doc/BRIEF.md
# CAN Bit Timing and Synchronization Unit

This block turns the module clock into time quanta and builds every CAN bit out of four consecutive segments: a one-quantum synchronization segment, a propagation segment, phase segment 1 and phase segment 2. At the boundary between the two phase segments it reads the receive line and reports the bit value with a one-cycle sample strobe. A second strobe marks the first cycle of each bit, which is where a transmitter would drive its next bit. All timing settings are static inputs. An error flag reports any combination of settings that cannot keep the bit in step with the bus.

The protocol logic supplies a bus-idle flag. While that flag is high, a falling edge on the receive line (recessive 1 to dominant 0) restarts the bit at once, so that the edge falls in the synchronization segment. While the flag is low, the first falling edge in a bit moves the sample point. A late edge lengthens phase segment 1, and an early edge shortens phase segment 2 or ends the bit. The correction is limited by a programmable jump width. With triple sampling enabled, the bit value is the majority of three reads of the line taken half a quantum apart.

The receive line passes through one synchronizing register inside the block. All outputs are registered. There is no data stream and no handshake: every pin is a plain control or status signal.

Top module: `can_bit_timing`

## Requirements
- R1: One time quantum lasts 2 × (`tq_div` + 1) clock cycles, with `tq_div` from 0 to 63. A bit lasts 1 + Lprop + Lph1 + Lph2 quanta. `tx_stb` is high for exactly one cycle at the first clock of each bit, so in steady state two pulses are one bit length apart.
- R2: The fields `prop_len_m1`, `ph1_len_m1` and `ph2_len_m1` each hold a segment length minus one, giving Lprop, Lph1 and Lph2 in the range 1 to 8 quanta. `jump_len_m1` holds the jump width minus one, giving Ljump in the range 1 to 4.
- R3: When `ph2_auto` is 1, Lph2 is the larger of Lph1 and 2, and `ph2_len_m1` is ignored.
- R4: The sample point is the end of phase segment 1. `sample_stb` goes high for one cycle, 2 × (`tq_div` + 1) × (1 + Lprop + Lph1) cycles after `tx_stb` when no correction applies. `bit_val` changes only in a cycle where `sample_stb` is high.
- R5: When `triple_en` is 0, `bit_val` is the receive line as it stood in the last clock of phase segment 1.
- R6: When `triple_en` is 1, `bit_val` is the majority of the line read at the sample point, half a quantum before it and one quantum before it.
- R7: While `bus_idle` is 1, a falling edge on `rx` restarts the bit. `tx_stb` rises two clocks after `rx` changes. No resynchronization is applied for the rest of that bit.
- R8: While `bus_idle` is 0, a first falling edge that lands in quantum k of the bit (the synchronization quantum is k = 0), inside the propagation segment or phase segment 1, lengthens phase segment 1 by min(k, Ljump).
- R9: A first falling edge in phase segment 2, with r quanta of the segment left (the current one included), starts a new bit on the next clock if r ≤ Ljump. Otherwise it shortens phase segment 2 by Ljump.
- R10: An edge inside the synchronization quantum makes no correction. Only the first falling edge of a bit is considered. Lengthening and shortening end at the next bit.
- R11: `cfg_err` is 1 exactly when Lprop + Lph1 < Lph2 or Lph2 ≤ Ljump.
- R12: During reset and just after it, `bit_val` is 1 (recessive) and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx | input | 1 | Receive line, 0 is dominant |
| bus_idle | input | 1 | High while the protocol logic sees the bus idle |
| tq_div | input | 6 | Quantum divider: the quantum lasts 2 × (value + 1) clocks |
| prop_len_m1 | input | 3 | Propagation segment length minus one |
| ph1_len_m1 | input | 3 | Phase segment 1 length minus one |
| ph2_len_m1 | input | 3 | Phase segment 2 length minus one |
| ph2_auto | input | 1 | Derive phase segment 2 from phase segment 1 |
| jump_len_m1 | input | 2 | Jump width minus one |
| triple_en | input | 1 | Enable three-read majority sampling |
| bit_val | output | 1 | Last sampled bit value |
| sample_stb | output | 1 | One-cycle pulse when bit_val updates |
| tx_stb | output | 1 | One-cycle pulse at the start of each bit |
| cfg_err | output | 1 | The timing settings are inconsistent |

## Verification
The bench places falling edges in specific quanta and measures when the sample strobe and the next bit-start strobe arrive. Each case has its own failure mode:
- An edge in the propagation segment and an edge far inside phase segment 1 expose a design that ignores the jump-width cap or measures the phase error from the wrong point. Either one shifts the sample strobe.
- Early edges one quantum inside and one quantum outside the jump width tell an immediate bit restart apart from a shortened phase segment 2. A design that confuses the two ends the bit one or more quanta off.
- A second edge in the same bit, an edge in the synchronization quantum, and an edge right after a hard synchronization must all leave the timing untouched. A design without the one-correction limit moves the sample point in these cases.
- A short dominant dip just before the sample point separates single reads from majority voting. A design with the wrong tap spacing takes the wrong vote.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] tq_div,
  input  logic             restart,
  output logic             tq_tick,
  output logic             half_tick
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] mid;

  // the quantum spans 2*(div+1) clocks; the midpoint sits half a quantum before the end
  assign last      = {tq_div, 1'b1};
  assign mid       = {1'b0, tq_div};
  assign tq_tick   = (cnt == last);
  assign half_tick = (cnt == mid);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || tq_tick) cnt <= '0;
    else                              cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
  parameter int SEG_W = 3,
  parameter int JMP_W = 2,
  parameter int LEN_W = SEG_W + 2
) (
  input  logic [SEG_W-1:0] prop_len_m1,
  input  logic [SEG_W-1:0] ph1_len_m1,
  input  logic [SEG_W-1:0] ph2_len_m1,
  input  logic             ph2_auto,
  input  logic [JMP_W-1:0] jump_len_m1,
  output logic [LEN_W-1:0] prop_len,
  output logic [LEN_W-1:0] ph1_len,
  output logic [LEN_W-1:0] ph2_len,
  output logic [LEN_W-1:0] jump_len,
  output logic             cfg_err
);
  localparam logic [LEN_W-1:0] IPT_LEN = LEN_W'(2);

  logic [LEN_W-1:0] ph2_prog;

  assign prop_len = LEN_W'(prop_len_m1) + 1'b1;
  assign ph1_len  = LEN_W'(ph1_len_m1) + 1'b1;
  assign ph2_prog = LEN_W'(ph2_len_m1) + 1'b1;
  assign jump_len = LEN_W'(jump_len_m1) + 1'b1;

  always_comb begin
    if (ph2_auto) ph2_len = (ph1_len > IPT_LEN) ? ph1_len : IPT_LEN;
    else          ph2_len = ph2_prog;
  end

  assign cfg_err = ((prop_len + ph1_len) < ph2_len) || (ph2_len <= jump_len);
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 5,
  parameter int POS_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             fall_edge,
  input  logic             bus_idle,
  input  logic [LEN_W-1:0] prop_len,
  input  logic [LEN_W-1:0] ph1_len,
  input  logic [LEN_W-1:0] ph2_len,
  input  logic [LEN_W-1:0] jump_len,
  output logic             restart,
  output logic             sample_pt,
  output logic             tx_stb
);
  seg_e             seg, seg_n;
  logic [LEN_W-1:0] cnt, cnt_n;
  logic [POS_W-1:0] pos, pos_n;
  logic [LEN_W-1:0] ext, ext_n;
  logic [LEN_W-1:0] cut, cut_n;
  logic             done, done_n;
  logic             new_bit;
  logic [LEN_W-1:0] ph2_left;
  logic [LEN_W-1:0] seg_len;

  assign ph2_left = ph2_len - cut - cnt;

  always_comb begin
    seg_n     = seg;
    cnt_n     = cnt;
    pos_n     = pos;
    ext_n     = ext;
    cut_n     = cut;
    done_n    = done;
    restart   = 1'b0;
    sample_pt = 1'b0;
    new_bit   = 1'b0;
    seg_len   = LEN_W'(1);

    // edge handling: hard sync while idle, otherwise one correction per bit
    if (fall_edge && bus_idle) begin
      restart = 1'b1;
    end else if (fall_edge && !done) begin
      done_n = 1'b1;
      unique case (seg)
        SEG_PROP, SEG_PH1:
          ext_n = (pos > POS_W'(jump_len)) ? jump_len : pos[LEN_W-1:0];
        SEG_PH2:
          if (ph2_left <= jump_len) restart = 1'b1;
          else                      cut_n   = jump_len;
        default: ;
      endcase
    end

    if (restart) begin
      seg_n   = SEG_SYNC;
      cnt_n   = '0;
      pos_n   = '0;
      ext_n   = '0;
      cut_n   = '0;
      done_n  = bus_idle;
      new_bit = 1'b1;
    end else if (tq_tick) begin
      pos_n = pos + 1'b1;
      unique case (seg)
        SEG_SYNC: seg_len = LEN_W'(1);
        SEG_PROP: seg_len = prop_len;
        SEG_PH1:  seg_len = ph1_len + ext_n;
        SEG_PH2:  seg_len = ph2_len - cut_n;
        default:  seg_len = LEN_W'(1);
      endcase
      if (cnt == seg_len - 1'b1) begin
        cnt_n = '0;
        unique case (seg)
          SEG_SYNC: seg_n = SEG_PROP;
          SEG_PROP: seg_n = SEG_PH1;
          SEG_PH1: begin
            seg_n     = SEG_PH2;
            sample_pt = 1'b1;
          end
          SEG_PH2: begin
            seg_n   = SEG_SYNC;
            pos_n   = '0;
            ext_n   = '0;
            cut_n   = '0;
            done_n  = 1'b0;
            new_bit = 1'b1;
          end
          default: seg_n = SEG_SYNC;
        endcase
      end else begin
        cnt_n = cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg    <= SEG_SYNC;
      cnt    <= '0;
      pos    <= '0;
      ext    <= '0;
      cut    <= '0;
      done   <= 1'b0;
      tx_stb <= 1'b0;
    end else begin
      seg    <= seg_n;
      cnt    <= cnt_n;
      pos    <= pos_n;
      ext    <= ext_n;
      cut    <= cut_n;
      done   <= done_n;
      tx_stb <= new_bit;
    end
  end
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
#(
  parameter int TAPS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_s,
  input  logic tq_tick,
  input  logic half_tick,
  input  logic sample_pt,
  input  logic triple_en,
  output logic bit_val,
  output logic sample_stb
);
  // taps[0] holds the read half a quantum back, taps[TAPS-1] the oldest
  logic [TAPS-1:0] taps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taps       <= '1;
      bit_val    <= 1'b1;
      sample_stb <= 1'b0;
    end else begin
      if (tq_tick || half_tick) taps <= {taps[TAPS-2:0], rx_s};
      sample_stb <= sample_pt;
      if (sample_pt) bit_val <= triple_en ? maj3(rx_s, taps[0], taps[1]) : rx_s;
    end
  end
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
#(
  parameter int DIV_W = 6,
  parameter int SEG_W = 3,
  parameter int JMP_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx,
  input  logic             bus_idle,
  input  logic [DIV_W-1:0] tq_div,
  input  logic [SEG_W-1:0] prop_len_m1,
  input  logic [SEG_W-1:0] ph1_len_m1,
  input  logic [SEG_W-1:0] ph2_len_m1,
  input  logic             ph2_auto,
  input  logic [JMP_W-1:0] jump_len_m1,
  input  logic             triple_en,
  output logic             bit_val,
  output logic             sample_stb,
  output logic             tx_stb,
  output logic             cfg_err
);
  localparam int LEN_W = SEG_W + 2;
  localparam int POS_W = LEN_W + 1;

  logic             rx_s, rx_d, fall_edge;
  logic             tq_tick, half_tick, restart, sample_pt;
  logic [LEN_W-1:0] prop_len, ph1_len, ph2_len, jump_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s <= 1'b1;
      rx_d <= 1'b1;
    end else begin
      rx_s <= rx;
      rx_d <= rx_s;
    end
  end

  assign fall_edge = rx_d & ~rx_s;

  can_bt_cfg #(.SEG_W(SEG_W), .JMP_W(JMP_W), .LEN_W(LEN_W)) u_cfg (
    .prop_len_m1 (prop_len_m1),
    .ph1_len_m1  (ph1_len_m1),
    .ph2_len_m1  (ph2_len_m1),
    .ph2_auto    (ph2_auto),
    .jump_len_m1 (jump_len_m1),
    .prop_len    (prop_len),
    .ph1_len     (ph1_len),
    .ph2_len     (ph2_len),
    .jump_len    (jump_len),
    .cfg_err     (cfg_err)
  );

  can_bt_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .tq_div    (tq_div),
    .restart   (restart),
    .tq_tick   (tq_tick),
    .half_tick (half_tick)
  );

  can_bt_seq #(.LEN_W(LEN_W), .POS_W(POS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tq_tick   (tq_tick),
    .fall_edge (fall_edge),
    .bus_idle  (bus_idle),
    .prop_len  (prop_len),
    .ph1_len   (ph1_len),
    .ph2_len   (ph2_len),
    .jump_len  (jump_len),
    .restart   (restart),
    .sample_pt (sample_pt),
    .tx_stb    (tx_stb)
  );

  can_bt_sampler #(.TAPS(2)) u_smp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_s       (rx_s),
    .tq_tick    (tq_tick),
    .half_tick  (half_tick),
    .sample_pt  (sample_pt),
    .triple_en  (triple_en),
    .bit_val    (bit_val),
    .sample_stb (sample_stb)
  );
endmodule

// File: rtl/can_bt_checker.sv
module can_bt_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_idle,
  input logic triple_en,
  input logic rx_s,
  input logic rx_d,
  input logic bit_val,
  input logic sample_stb,
  input logic tx_stb
);
  AST_STB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb)); // R4
  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb); // R4
  AST_VAL_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_val) |-> sample_stb); // R4
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && !triple_en) |-> (bit_val == $past(rx_s))); // R5
  AST_HARD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && rx_d && !rx_s) |=> tx_stb); // R7
endmodule

bind can_bit_timing can_bt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_idle   (bus_idle),
  .triple_en  (triple_en),
  .rx_s       (rx_s),
  .rx_d       (rx_d),
  .bit_val    (bit_val),
  .sample_stb (sample_stb),
  .tx_stb     (tx_stb)
);

// File: tb/tb_can_bit_timing.sv
module tb_can_bit_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       bus_idle = 1'b0;
  logic [5:0] tq_div = '0;
  logic [2:0] prop_len_m1 = '0, ph1_len_m1 = '0, ph2_len_m1 = '0;
  logic       ph2_auto = 1'b0;
  logic [1:0] jump_len_m1 = '0;
  logic       triple_en = 1'b0;
  logic       bit_val, sample_stb, tx_stb, cfg_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  can_bit_timing dut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .bus_idle(bus_idle), .tq_div(tq_div),
    .prop_len_m1(prop_len_m1), .ph1_len_m1(ph1_len_m1), .ph2_len_m1(ph2_len_m1),
    .ph2_auto(ph2_auto), .jump_len_m1(jump_len_m1), .triple_en(triple_en),
    .bit_val(bit_val), .sample_stb(sample_stb), .tx_stb(tx_stb), .cfg_err(cfg_err)
  );

  // fields are length-minus-one codes; expected lengths in quanta
  typedef struct packed {
    int dv; int pr; int p1; int p2; int au; int jw;
    int err; int bit_tq; int sp_tq;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{0, 0, 1, 1, 0, 0, 0,  6, 4},
    '{3, 2, 3, 2, 0, 1, 0, 11, 8},
    '{0, 0, 0, 7, 1, 0, 0,  5, 3},
    '{1, 1, 4, 0, 1, 1, 0, 13, 8},
    '{0, 0, 0, 2, 0, 0, 1,  0, 0},
    '{0, 3, 3, 1, 0, 1, 1,  0, 0},
    '{63, 0, 1, 1, 0, 0, 0, 6, 4}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int dv, input int pr, input int p1, input int p2,
                          input int au, input int jw, input int tr);
    @(negedge clk);
    rst_n = 1'b0; rx = 1'b1; bus_idle = 1'b0;
    tq_div = 6'(dv); prop_len_m1 = 3'(pr); ph1_len_m1 = 3'(p1);
    ph2_len_m1 = 3'(p2); ph2_auto = au[0]; jump_len_m1 = 2'(jw); triple_en = tr[0];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sync_tx();
    do @(negedge clk); while (!tx_stb);
  endtask

  // starts on the negedge where tx_stb was seen (cycle 0); a drive at cycle c reaches the block at c+1
  task automatic run_bit(input int c0, input int v0, input int c1, input int v1,
                         input int c2, input int v2,
                         output int s, output int t, output int bv);
    s = -1; t = -1; bv = -1; cyc = 0;
    for (int k = 0; k < 3000; k++) begin
      if (cyc == c0) rx = v0[0];
      if (cyc == c1) rx = v1[0];
      if (cyc == c2) rx = v2[0];
      @(negedge clk);
      cyc++;
      if (sample_stb && s < 0) begin s = cyc; bv = int'(bit_val); end
      if (tx_stb) begin t = cyc; break; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s, t, bv, n;
    // reset state, R12
    do_reset(0, 0, 3, 3, 0, 1, 0);
    check("R12 bit_val in reset", int'(bit_val), 1);
    check("R12 sample_stb in reset", int'(sample_stb), 0);
    check("R12 tx_stb in reset", int'(tx_stb), 0);
    @(negedge clk);
    check("R12 bit_val after reset", int'(bit_val), 1);
    check("R12 tx_stb after reset", int'(tx_stb), 0);

    // table walk: quantum size, bit length, sample point, auto phase 2, config error
    for (int i = 0; i < 7; i++) begin
      do_reset(VECS[i].dv, VECS[i].pr, VECS[i].p1, VECS[i].p2, VECS[i].au, VECS[i].jw, 0);
      check("R11 cfg_err", int'(cfg_err), VECS[i].err);
      if (VECS[i].err == 0) begin
        n = 2 * (VECS[i].dv + 1);
        sync_tx();
        run_bit(-1, 1, -1, 1, -1, 1, s, t, bv);
        check("R4 R2 R3 sample point", s, n * VECS[i].sp_tq);
        check("R1 R2 R3 bit length", t, n * VECS[i].bit_tq);
        check("R5 idle line value", bv, 1);
      end
    end

    // directed config: quantum 2 clocks, prop 1, ph1 4, ph2 4, jump 2: bit 20 clocks, sample 12
    do_reset(0, 0, 3, 3, 0, 1, 0);
    sync_tx();
    run_bit(1, 0, 4, 1, -1, 1, s, t, bv);
    check("R8 late edge in prop: sample", s, 14);
    check("R8 late edge in prop: bit end", t, 22);
    run_bit(7, 0, 10, 1, -1, 1, s, t, bv);
    check("R8 late edge capped by jump: sample", s, 16);
    check("R8 late edge capped by jump: bit end", t, 24);
    run_bit(-1, 1, -1, 1, -1, 1, s, t, bv);
    check("R10 adjustments restored: sample", s, 12);
    check("R10 adjustments restored: bit end", t, 20);
    run_bit(13, 0, 14, 1, -1, 1, s, t, bv);
    check("R9 early edge shortens ph2", t, 16);
    run_bit(15, 0, 16, 1, -1, 1, s, t, bv);
    check("R9 early edge within jump restarts bit", t, 17);
    run_bit(0, 0, 3, 1, 7, 0, s, t, bv);
    check("R10 sync edge and second edge ignored: sample", s, 12);
    check("R10 sync edge and second edge ignored: bit end", t, 20);
    check("R5 single read sees dominant", bv, 0);
    rx = 1'b1;
    run_bit(-1, 1, -1, 1, -1, 1, s, t, bv);
    check("R5 line back to recessive", bv, 1);

    // hard synchronization while idle
    bus_idle = 1'b1;
    run_bit(5, 0, -1, 1, -1, 1, s, t, bv);
    check("R7 hard sync restart two clocks after rx", t, 7);
    bus_idle = 1'b0;
    run_bit(1, 1, 3, 0, -1, 1, s, t, bv);
    check("R7 no resync after hard sync: sample", s, 12);
    check("R7 no resync after hard sync: bit end", t, 20);
    check("R7 dominant sampled", bv, 0);

    // majority sampling: quantum 4 clocks, prop 1, ph1 2, ph2 2, sample strobe at 16
    do_reset(1, 0, 1, 1, 0, 0, 0);
    sync_tx();
    run_bit(0, 0, 2, 1, 13, 0, s, t, bv);
    check("R5 single read takes late dip: sample", s, 16);
    check("R5 single read takes late dip", bv, 0);
    do_reset(1, 0, 1, 1, 0, 0, 1);
    sync_tx();
    run_bit(0, 0, 2, 1, 13, 0, s, t, bv);
    check("R6 majority rejects one dominant read", bv, 1);
    check("R6 bit end unaffected", t, 24);
    do_reset(1, 0, 1, 1, 0, 0, 1);
    sync_tx();
    run_bit(0, 0, 2, 1, 11, 0, s, t, bv);
    check("R6 majority of two dominant reads", bv, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule